// File: doc/BRIEF.md
# DDR2 Bank Precharge and Activate Timing Guard

This block watches the command stream of a single DRAM bank, one command per clock. It keeps one down-counter for each timing window that limits when the bank may be closed or reopened. Every cycle it reports whether a precharge or an activate would be legal if issued now. A memory controller's scheduler uses these two flags to gate its choices. A checker uses the violation pulse and its code to catch a command sequence that breaks a rule.

The earliest legal precharge after a read depends on the posted additive latency, half the burst length and any read-to-precharge time beyond two clocks. The earliest legal precharge after a write depends on the write latency (read latency minus one), half the burst length and a write-recovery clock count. That count is a separate configuration input and is not tied to any mode-register field. No precharge may cut a burst short. Timing inputs are expected to stay constant while the bank is in use and are changed only under reset.

Top module: `bank_timing_guard`

## Requirements
- R1: During and after a synchronous active-high reset the bank is closed, `act_ok` is 1, and `pre_ok`, `viol` and `viol_code` are 0.
- R2: After an accepted READ at cycle t, a PRECHARGE is blocked until cycle t + AL + BL/2 + max(0, tRTP − 2). A PRECHARGE at or after t + AL + BL/2 but before that limit gives code 3. `cfg_bl8` = 1 selects BL 8 (BL/2 = 4), and 0 selects BL 4 (BL/2 = 2).
- R3: After an accepted WRITE at cycle t, a PRECHARGE is blocked until t + (AL + CL − 1) + BL/2 + tWR. A PRECHARGE in the recovery part of that window gives code 4.
- R4: A PRECHARGE less than tRAS cycles after the accepted ACTIVATE gives code 2.
- R5: An ACTIVATE less than tRP cycles after the accepted PRECHARGE gives code 6. Otherwise, an ACTIVATE less than tRC cycles after the previous accepted ACTIVATE gives code 7.
- R6: `pre_ok` is 1 exactly when the bank is open and the tRAS, read-to-precharge and write-to-precharge windows have all expired. `act_ok` is 1 exactly when the bank is closed and the tRP and tRC windows have both expired.
- R7: A command that breaks a rule raises `viol` for one cycle, in the cycle after the command, with a nonzero `viol_code`. `viol_code` is 0 whenever `viol` is 0. For a PRECHARGE the rules are checked in this order: closed bank, burst in progress, tRAS, read-to-precharge, write recovery.
- R8: A PRECHARGE less than AL + BL/2 cycles after a READ, or less than (AL + CL − 1) + BL/2 cycles after a WRITE, interrupts a burst and gives code 5.
- R9: A READ, WRITE or PRECHARGE to a closed bank, or an ACTIVATE to an open bank, gives code 1.
- R10: A command that is flagged changes no timing or open/closed state. The `pre_ok` and `act_ok` flags in the next cycle match the state as if the command had been a NOP.
- R11: Command encoding: NOP 0, ACTIVATE 1, READ 2, WRITE 3, PRECHARGE 4. NOP and the unused codes 5 to 7 never raise `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command seen this cycle (encoding in R11) |
| cfg_al | input | LAT_W | Additive latency in clocks |
| cfg_cl | input | LAT_W | CAS latency in clocks |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects burst length 4 |
| cfg_trtp | input | TIM_W | Read-to-precharge time in clocks |
| cfg_twr | input | TIM_W | Write-recovery time in clocks |
| cfg_tras | input | TIM_W | Activate-to-precharge minimum in clocks |
| cfg_trp | input | TIM_W | Precharge-to-activate minimum in clocks |
| cfg_trc | input | TIM_W | Activate-to-activate minimum in clocks |
| pre_ok | output | 1 | A precharge issued now would be legal |
| act_ok | output | 1 | An activate issued now would be legal |
| viol | output | 1 | Rule broken by the previous cycle's command |
| viol_code | output | 3 | 0 none, 1 protocol, 2 tRAS, 3 tRTP, 4 tWR, 5 burst, 6 tRP, 7 tRC |

## Verification
`viol` and `viol_code` are registered and are due exactly one clock after the command that caused them. `pre_ok` and `act_ok` are decoded from counters and already account for every command up to the previous clock edge. The bench drives each command on the falling edge. At that same falling edge it first compares `viol` and `viol_code` with the expectation stored for the previous command, then compares the two ready flags with its model for the current cycle. The bench model keeps only the cycle numbers of the last accepted activate, read, write and precharge and compares their distances with the spacing formulas. This gives a reference that does not mirror the counter structure.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_PROTO = 3'd1,
    ERR_RAS   = 3'd2,
    ERR_RTP   = 3'd3,
    ERR_WREC  = 3'd4,
    ERR_BURST = 3'd5,
    ERR_RP    = 3'd6,
    ERR_RC    = 3'd7
  } err_e;

  // timing window slots
  localparam int NWIN    = 7;
  localparam int WIN_RAS = 0;
  localparam int WIN_RDB = 1;  // read burst still being fetched
  localparam int WIN_RD  = 2;  // full read-to-precharge
  localparam int WIN_WRB = 3;  // write burst data still arriving
  localparam int WIN_WR  = 4;  // full write-to-precharge incl. recovery
  localparam int WIN_RP  = 5;
  localparam int WIN_RC  = 6;

endpackage

// File: rtl/bg_window_ctr.sv
module bg_window_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         idle
);

  logic [W-1:0] cnt;

  // span S loaded as S-1 so the window reads idle exactly S cycles later
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= (span == '0) ? '0 : span - 1'b1;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

endmodule

// File: rtl/bg_spacing.sv
module bg_spacing #(
  parameter int LAT_W = 4,
  parameter int TIM_W = 6,
  parameter int CNT_W = 8
) (
  input  logic [LAT_W-1:0] al,
  input  logic [LAT_W-1:0] cl,
  input  logic             bl8,
  input  logic [TIM_W-1:0] trtp,
  input  logic [TIM_W-1:0] twr,
  output logic [CNT_W-1:0] rdb_span,
  output logic [CNT_W-1:0] rd_span,
  output logic [CNT_W-1:0] wrb_span,
  output logic [CNT_W-1:0] wr_span
);

  logic [CNT_W-1:0] al_x, cl_x, half, wl, extra, rtp_x;

  always_comb begin
    al_x  = CNT_W'(al);
    cl_x  = CNT_W'(cl);
    rtp_x = CNT_W'(trtp);
    half  = bl8 ? CNT_W'(4) : CNT_W'(2);
    wl    = ((al_x + cl_x) == '0) ? '0 : (al_x + cl_x - 1'b1);
    extra = (rtp_x > CNT_W'(2)) ? (rtp_x - CNT_W'(2)) : '0;

    rdb_span = al_x + half;
    rd_span  = al_x + half + extra;
    wrb_span = wl + half;
    wr_span  = wl + half + CNT_W'(twr);
  end

endmodule

// File: rtl/bg_rules.sv
module bg_rules
  import bank_guard_pkg::*;
(
  input  cmd_e            cmd,
  input  logic            is_open,
  input  logic [NWIN-1:0] idle,
  output err_e            err
);

  always_comb begin
    err = ERR_NONE;
    unique case (cmd)
      CMD_ACT: begin
        if (is_open)            err = ERR_PROTO;
        else if (!idle[WIN_RP]) err = ERR_RP;
        else if (!idle[WIN_RC]) err = ERR_RC;
      end
      CMD_RD, CMD_WR: begin
        if (!is_open) err = ERR_PROTO;
      end
      CMD_PRE: begin
        if (!is_open)                             err = ERR_PROTO;
        else if (!idle[WIN_RDB] || !idle[WIN_WRB]) err = ERR_BURST;
        else if (!idle[WIN_RAS])                  err = ERR_RAS;
        else if (!idle[WIN_RD])                   err = ERR_RTP;
        else if (!idle[WIN_WR])                   err = ERR_WREC;
      end
      default: err = ERR_NONE;
    endcase
  end

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bank_guard_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int TIM_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic [LAT_W-1:0] cfg_al,
  input  logic [LAT_W-1:0] cfg_cl,
  input  logic             cfg_bl8,
  input  logic [TIM_W-1:0] cfg_trtp,
  input  logic [TIM_W-1:0] cfg_twr,
  input  logic [TIM_W-1:0] cfg_tras,
  input  logic [TIM_W-1:0] cfg_trp,
  input  logic [TIM_W-1:0] cfg_trc,
  output logic             pre_ok,
  output logic             act_ok,
  output logic             viol,
  output logic [2:0]       viol_code
);

  cmd_e             cmd_c;
  err_e             err;
  logic             accept;
  logic             is_open;
  logic             viol_q;
  err_e             code_q;
  logic [NWIN-1:0]  load_v;
  logic [NWIN-1:0]  idle_v;
  logic [CNT_W-1:0] span_v [NWIN];
  logic [CNT_W-1:0] rdb_span, rd_span, wrb_span, wr_span;

  assign cmd_c = cmd_e'(cmd);

  bg_spacing #(.LAT_W(LAT_W), .TIM_W(TIM_W), .CNT_W(CNT_W)) u_spacing (
    .al       (cfg_al),
    .cl       (cfg_cl),
    .bl8      (cfg_bl8),
    .trtp     (cfg_trtp),
    .twr      (cfg_twr),
    .rdb_span (rdb_span),
    .rd_span  (rd_span),
    .wrb_span (wrb_span),
    .wr_span  (wr_span)
  );

  bg_rules u_rules (
    .cmd     (cmd_c),
    .is_open (is_open),
    .idle    (idle_v),
    .err     (err)
  );

  assign accept = (err == ERR_NONE);

  // per-window load strobe and span
  always_comb begin
    load_v[WIN_RAS] = accept && (cmd_c == CMD_ACT);
    load_v[WIN_RC]  = accept && (cmd_c == CMD_ACT);
    load_v[WIN_RDB] = accept && (cmd_c == CMD_RD);
    load_v[WIN_RD]  = accept && (cmd_c == CMD_RD);
    load_v[WIN_WRB] = accept && (cmd_c == CMD_WR);
    load_v[WIN_WR]  = accept && (cmd_c == CMD_WR);
    load_v[WIN_RP]  = accept && (cmd_c == CMD_PRE);

    span_v[WIN_RAS] = CNT_W'(cfg_tras);
    span_v[WIN_RC]  = CNT_W'(cfg_trc);
    span_v[WIN_RDB] = rdb_span;
    span_v[WIN_RD]  = rd_span;
    span_v[WIN_WRB] = wrb_span;
    span_v[WIN_WR]  = wr_span;
    span_v[WIN_RP]  = CNT_W'(cfg_trp);
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    bg_window_ctr #(.W(CNT_W)) u_win (
      .clk  (clk),
      .rst  (rst),
      .load (load_v[g]),
      .span (span_v[g]),
      .idle (idle_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      viol_q  <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      if (accept && cmd_c == CMD_ACT)      is_open <= 1'b1;
      else if (accept && cmd_c == CMD_PRE) is_open <= 1'b0;
      viol_q <= !accept;
      code_q <= err;
    end
  end

  assign pre_ok    = is_open && idle_v[WIN_RAS] && idle_v[WIN_RD] && idle_v[WIN_WR];
  assign act_ok    = !is_open && idle_v[WIN_RP] && idle_v[WIN_RC];
  assign viol      = viol_q;
  assign viol_code = code_q;

endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd,
  input logic       pre_ok,
  input logic       act_ok,
  input logic       viol,
  input logic [2:0] viol_code
);

  // R7
  code_match_chk: assert property (@(posedge clk) disable iff (rst)
    viol == (viol_code != 3'd0));

  // R6
  ok_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(pre_ok && act_ok));

  // R11
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd0 || cmd > 3'd4) |=> !viol);

  // R6
  pre_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd4 && pre_ok) |=> (!viol && !pre_ok));

  // R5
  act_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd1 && act_ok) |=> (!viol && !act_ok));

  // R9
  closed_read_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 3'd2 || cmd == 3'd3) && act_ok) |=> (viol && viol_code == 3'd1));

endmodule

bind bank_timing_guard bank_timing_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .pre_ok    (pre_ok),
  .act_ok    (act_ok),
  .viol      (viol),
  .viol_code (viol_code)
);

// File: tb/bank_timing_guard_tb.sv
`timescale 1ns/1ps
module bank_timing_guard_tb;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd = NOP;
  logic [3:0] cfg_al = '0, cfg_cl = 4'd4;
  logic       cfg_bl8 = 1'b0;
  logic [5:0] cfg_trtp = 6'd2, cfg_twr = 6'd3, cfg_tras = 6'd4, cfg_trp = 6'd2, cfg_trc = 6'd6;
  logic       pre_ok, act_ok, viol;
  logic [2:0] viol_code;

  int tests = 0, fails = 0, n = 0;
  int last_act, last_rd, last_wr, last_pre;
  bit mopen;
  int al, cl, bl8, trtp, twr, tras, trp, trc;
  logic [2:0] pend_code, pend_cmd;

  always #4 clk = ~clk;

  bank_timing_guard u_dut (
    .clk(clk), .rst(rst), .cmd(cmd),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
    .cfg_trtp(cfg_trtp), .cfg_twr(cfg_twr), .cfg_tras(cfg_tras),
    .cfg_trp(cfg_trp), .cfg_trc(cfg_trc),
    .pre_ok(pre_ok), .act_ok(act_ok), .viol(viol), .viol_code(viol_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, n);
    end
  endtask

  function automatic int half(); return bl8 ? 4 : 2; endfunction
  function automatic int rdb_gap(); return al + half(); endfunction
  function automatic int rd_gap(); return al + half() + ((trtp > 2) ? trtp - 2 : 0); endfunction
  function automatic int wrb_gap(); return al + cl - 1 + half(); endfunction
  function automatic int wr_gap(); return al + cl - 1 + half() + twr; endfunction

  function automatic bit exp_pre_ok();
    return mopen && (n - last_act >= tras) && (n - last_rd >= rd_gap()) && (n - last_wr >= wr_gap());
  endfunction

  function automatic bit exp_act_ok();
    return !mopen && (n - last_pre >= trp) && (n - last_act >= trc);
  endfunction

  function automatic logic [2:0] exp_code(input logic [2:0] c);
    case (c)
      ACT: begin
        if (mopen) return 3'd1;
        if (n - last_pre < trp) return 3'd6;
        if (n - last_act < trc) return 3'd7;
      end
      RD, WR: if (!mopen) return 3'd1;
      PRE: begin
        if (!mopen) return 3'd1;
        if (n - last_rd < rdb_gap() || n - last_wr < wrb_gap()) return 3'd5;
        if (n - last_act < tras) return 3'd2;
        if (n - last_rd < rd_gap()) return 3'd3;
        if (n - last_wr < wr_gap()) return 3'd4;
      end
      default: return 3'd0;
    endcase
    return 3'd0;
  endfunction

  function automatic string tag_for(input logic [2:0] code, input logic [2:0] c);
    case (code)
      3'd0: return (c == NOP || c > PRE) ? "R11" : "R7";
      3'd1: return "R9";
      3'd2: return "R4";
      3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic step(input logic [2:0] c);
    logic [2:0] e;
    string t;
    @(negedge clk);
    t = tag_for(pend_code, pend_cmd);
    chk(viol === (pend_code != 3'd0), t, int'(viol), int'(pend_code != 3'd0));
    chk(viol_code === pend_code, t, int'(viol_code), int'(pend_code));
    t = (pend_code != 3'd0) ? "R10" : "R6";
    chk(pre_ok === exp_pre_ok(), t, int'(pre_ok), int'(exp_pre_ok()));
    chk(act_ok === exp_act_ok(), t, int'(act_ok), int'(exp_act_ok()));
    cmd = c;
    e = exp_code(c);
    if (e == 3'd0) begin
      case (c)
        ACT: begin last_act = n; mopen = 1'b1; end
        RD:  last_rd = n;
        WR:  last_wr = n;
        PRE: begin last_pre = n; mopen = 1'b0; end
        default: ;
      endcase
    end
    pend_code = e;
    pend_cmd  = c;
    n++;
  endtask

  task automatic nops(input int k);
    for (int i = 0; i < k; i++) step(NOP);
  endtask

  task automatic do_reset(input int a, input int c, input int b8, input int rtp,
                          input int wrc, input int ras, input int rp, input int rc);
    al = a; cl = c; bl8 = b8; trtp = rtp; twr = wrc; tras = ras; trp = rp; trc = rc;
    cfg_al = 4'(a); cfg_cl = 4'(c); cfg_bl8 = 1'(b8);
    cfg_trtp = 6'(rtp); cfg_twr = 6'(wrc); cfg_tras = 6'(ras); cfg_trp = 6'(rp); cfg_trc = 6'(rc);
    rst = 1'b1;
    cmd = NOP;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0; mopen = 1'b0;
    last_act = -1000; last_rd = -1000; last_wr = -1000; last_pre = -1000;
    pend_code = 3'd0; pend_cmd = NOP;
    // R1 reset state
    chk(act_ok === 1'b1, "R1", int'(act_ok), 1);
    chk(pre_ok === 1'b0, "R1", int'(pre_ok), 0);
    chk(viol === 1'b0, "R1", int'(viol), 0);
    chk(viol_code === 3'd0, "R1", int'(viol_code), 0);
  endtask

  function automatic logic [2:0] pick();
    int r;
    r = $urandom_range(0, 9);
    if (r < 4) return NOP;
    if (r < 7) begin
      if (exp_act_ok()) return ACT;
      if (exp_pre_ok()) return PRE;
      if (mopen) return ($urandom_range(0, 3) == 0) ? WR : (($urandom_range(0, 3) == 0) ? RD : NOP);
      return NOP;
    end
    return 3'($urandom_range(0, 7));
  endfunction

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));

    // directed: AL=2 CL=4 BL4, tRTP=3 (one extra clock), tWR=3
    do_reset(2, 4, 0, 3, 3, 4, 2, 7);
    step(ACT);           // n0
    step(PRE);           // n1 tRAS (R4)
    step(RD);            // n2
    step(PRE);           // n3 burst interrupt (R8)
    nops(2);
    step(PRE);           // n6 inside tRTP extension (R2)
    step(PRE);           // n7 legal
    step(ACT);           // n8 tRP (R5)
    step(ACT);           // n9 legal
    step(WR);            // n10
    step(RD);            // n11
    nops(5);
    step(PRE);           // n17 write recovery (R3)
    nops(2);
    step(PRE);           // n20 legal
    step(RD);            // n21 closed bank (R9)
    step(ACT);           // n22
    nops(3);
    step(PRE);           // n26
    nops(1);
    step(ACT);           // n28 tRC (R5)
    step(ACT);           // n29 legal
    step(ACT);           // n30 already open (R9)
    step(3'd6);          // unused code (R11)
    nops(3);

    // directed: AL=0 CL=4 BL8 tRTP=2
    do_reset(0, 4, 1, 2, 4, 3, 3, 6);
    step(ACT);
    nops(3);
    step(RD);
    nops(2);
    step(PRE);           // 3 after read: burst (R8)
    step(PRE);           // 4 after read: legal (R2)
    nops(4);

    // random phases
    for (int ph = 0; ph < 8; ph++) begin
      int ras, rp;
      ras = $urandom_range(3, 12);
      rp  = $urandom_range(2, 6);
      do_reset($urandom_range(0, 4), $urandom_range(3, 6), $urandom_range(0, 1),
               $urandom_range(1, 4), $urandom_range(2, 6), ras, rp,
               ras + rp + $urandom_range(0, 3));
      for (int k = 0; k < 2000; k++) step(pick());
      nops(2);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule